// File: doc/BRIEF.md
# I2C EEPROM Slave Write Controller

This block is a synthesizable I2C target that behaves like a 128-byte serial EEPROM. The write path gets the most attention. It samples SCL and SDA on a fast system clock and pulls SDA low only through an open-drain enable. It recognises its own device address through three strapped pins and takes a word address. It then gathers either one data byte or a page of up to eight bytes in a small page buffer.

On the closing stop, a self-timed write cycle starts, measured in system clocks. The buffered bytes go into the storage array only when that cycle ends. While the cycle runs, the block ignores the bus completely. A master therefore learns that the write has finished by sending the device address repeatedly until it is acknowledged. Random reads and current-address reads are supported in a minimal form.

The control state machine has these states:
- `ST_IDLE`: waiting for a start.
- `ST_DEV`: shifting in the device byte.
- `ST_DEV_ACK`: acknowledge of the device byte.
- `ST_WADDR`: shifting in the word address.
- `ST_WADDR_ACK`: acknowledge of the word address.
- `ST_WDATA`: shifting in a data byte.
- `ST_WDATA_ACK`: acknowledge of a data byte.
- `ST_RDATA`: shifting out a read byte.
- `ST_RACK`: sampling the master's acknowledge.

The state machine moves as follows:
- A start moves any state to `ST_DEV`. A stop moves any state to `ST_IDLE`. A busy write cycle holds the machine in `ST_IDLE`.
- `ST_DEV` goes to `ST_DEV_ACK` on an address match and to `ST_IDLE` otherwise.
- From `ST_DEV_ACK`, a read goes to `ST_RDATA` and a write goes to `ST_WADDR`.
- `ST_WADDR` goes to `ST_WADDR_ACK`, then to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate.
- `ST_RDATA` goes to `ST_RACK`. `ST_RACK` returns to `ST_RDATA` on a master acknowledge and goes to `ST_IDLE` on a not-acknowledge.

Top module: `eeprom_wr_slave`

## Requirements
- R1: A device byte is accepted only if its bits 7:4 equal binary 1010. With any other prefix the ninth clock is left high (no acknowledge).
- R2: Bits 3:1 of the device byte must equal `addr_pins_i` (bit 3 against pin 2). On a mismatch the block gives no acknowledge, stays silent and ignores further bytes until the next start.
- R3: On a match while not busy, the block pulls SDA low for the ninth clock. Bit 0 of the device byte selects the direction: 1 is a read and 0 is a write. `sda_oe_o` changes only while the synchronised SCL is low.
- R4: In a write, the byte after the device byte is the word address (its low 7 bits are used). That byte and every data byte that follows are acknowledged.
- R5: After each data byte, only the low 3 bits of the word address increment. The upper 4 bits stay fixed, so an address past offset 7 wraps to offset 0 of the same page.
- R6: When more than 8 data bytes are sent in one transfer, later bytes overwrite earlier ones at the same page offset. The last byte written to each offset is the one stored.
- R7: A stop after at least one data byte starts the write cycle. `busy_o` rises on the third system clock edge after SDA rises at the pin and stays high for exactly `WR_CYCLES` clocks. The buffered bytes reach the array when the cycle ends.
- R8: While `busy_o` is high, `sda_oe_o` stays 0 and no device byte is acknowledged, even one that matches.
- R9: Once `busy_o` has fallen, a start followed by a matching device byte is acknowledged and the transfer continues normally (acknowledge polling).
- R10: A read returns bytes MSB first, starting at the current address. The address advances through the whole array after each byte sent. A master acknowledge asks for the next byte and a not-acknowledge ends the read. A random read is a write of the word address, a repeated start, then a read.
- R11: A stop before any data byte has been received starts no write cycle.
- R12: A repeated start discards page-buffer bytes that have not been committed. A later stop with no new data starts no write cycle and leaves the array unchanged.
- R13: After reset every array byte reads 0, `busy_o` is 0 and `sda_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| addr_pins_i | input | 3 | Strapped device address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| busy_o | output | 1 | High for the whole internal write cycle |

## Verification
A corrupted bit counter or state shows up at the ports within one byte time. An acknowledge then appears one clock early or late, or is missing, on the ninth SCL pulse. A wrong page pointer or a stale buffer-valid mask does not show at once. It surfaces only when the written page is read back after the write cycle, so each page write is followed by a full-page read. A wrong busy timer shows on `busy_o` on the first clock where it differs from the reference countdown, which is compared on every clock.

// File: rtl/eew_pkg.sv
package eew_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } eew_state_e;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

endpackage

// File: rtl/eew_busfront.sv
module eew_busfront (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_m;
    logic [1:0] sda_m;
    logic       scl_p;
    logic       sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_m <= 2'b11;
            sda_m <= 2'b11;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_m <= {scl_m[0], scl_i};
            sda_m <= {sda_m[0], sda_i};
            scl_p <= scl_m[1];
            sda_p <= sda_m[1];
        end
    end

    assign scl_s     = scl_m[1];
    assign sda_s     = sda_m[1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/eew_wtimer.sv
module eew_wtimer #(
    parameter int WR_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end else if (launch) begin
            cnt <= CW'(WR_CYCLES);
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

endmodule

// File: rtl/eew_store.sv
module eew_store #(
    parameter int ADDR_W = 7,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_buf,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_off,
    input  logic [7:0]        wr_data,
    input  logic              commit,
    input  logic [ADDR_W-PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              any_valid
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SLOTS = 1 << PAGE_W;

    logic [7:0]       slot_q [SLOTS];
    logic [SLOTS-1:0] vld;
    logic [7:0]       word_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_q[wr_off] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (clr_buf || commit) begin
            vld <= '0;
        end else if (wr_en) begin
            vld[wr_off] <= 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        localparam logic [ADDR_W-PAGE_W-1:0] MY_PAGE = (ADDR_W-PAGE_W)'(g >> PAGE_W);
        localparam int MY_OFF = g % SLOTS;
        logic [7:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (commit && vld[MY_OFF] && page == MY_PAGE) begin
                q <= slot_q[MY_OFF];
            end
        end
        assign word_q[g] = q;
    end

    assign rd_data   = word_q[rd_addr];
    assign any_valid = |vld;

endmodule

// File: rtl/eeprom_wr_slave.sv
module eeprom_wr_slave
    import eew_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int PAGE_W    = 3,
    parameter int WR_CYCLES = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] addr_pins_i,
    output logic       sda_oe_o,
    output logic       busy_o
);
    localparam int PG_W = ADDR_W - PAGE_W;

    eew_state_e        state, nxt;
    logic [3:0]        bitcnt;
    logic [7:0]        sreg;
    logic [7:0]        osh;
    logic [ADDR_W-1:0] ptr;
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              busy, done, launch, buf_any, clr_buf, wr_en, dev_hit, byte_end;
    logic [7:0]        rd_data;

    eew_busfront u_front (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eew_wtimer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .done(done)
    );

    eew_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr_buf(clr_buf), .wr_en(wr_en),
        .wr_off(ptr[PAGE_W-1:0]), .wr_data(sreg), .commit(done),
        .page(ptr[ADDR_W-1:PAGE_W]), .rd_addr(ptr), .rd_data(rd_data),
        .any_valid(buf_any)
    );

    assign byte_end = (bitcnt == BITS_PER_BYTE);
    assign dev_hit  = (sreg[7:4] == DEV_PREFIX) && (sreg[3:1] == addr_pins_i);
    assign launch   = stop_det & buf_any & ~busy;
    assign clr_buf  = start_det & ~busy;
    assign wr_en    = ~busy & scl_fall & (state == ST_WDATA) & byte_end;
    assign busy_o   = busy;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next-state decode
    always_comb begin
        nxt = state;
        if (busy) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_DEV;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else if (scl_fall) begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_DEV:       if (byte_end) nxt = dev_hit ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   nxt = sreg[0] ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (byte_end) nxt = ST_WADDR_ACK;
                ST_WADDR_ACK: nxt = ST_WDATA;
                ST_WDATA:     if (byte_end) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: nxt = ST_WDATA;
                ST_RDATA:     if (byte_end) nxt = ST_RACK;
                ST_RACK:      nxt = sreg[0] ? ST_IDLE : ST_RDATA;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe_o <= 1'b0;
            bitcnt   <= '0;
            sreg     <= '0;
            osh      <= '0;
            ptr      <= '0;
        end else if (busy || start_det || stop_det) begin
            sda_oe_o <= 1'b0;
            bitcnt   <= '0;
        end else if (scl_rise) begin
            if (state inside {ST_DEV, ST_WADDR, ST_WDATA, ST_RDATA, ST_RACK}) begin
                sreg   <= {sreg[6:0], sda_s};
                bitcnt <= bitcnt + 4'd1;
            end
        end else if (scl_fall) begin
            unique case (state)
                ST_DEV: begin
                    if (byte_end) begin
                        sda_oe_o <= dev_hit;
                        bitcnt   <= '0;
                    end
                end
                ST_WADDR: begin
                    if (byte_end) begin
                        ptr      <= sreg[ADDR_W-1:0];
                        sda_oe_o <= 1'b1;
                        bitcnt   <= '0;
                    end
                end
                ST_WDATA: begin
                    if (byte_end) begin
                        ptr      <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
                        sda_oe_o <= 1'b1;
                        bitcnt   <= '0;
                    end
                end
                ST_RDATA: begin
                    if (byte_end) begin
                        sda_oe_o <= 1'b0;
                        bitcnt   <= '0;
                    end else begin
                        osh      <= {osh[6:0], 1'b0};
                        sda_oe_o <= ~osh[6];
                    end
                end
                ST_DEV_ACK, ST_RACK: begin
                    bitcnt <= '0;
                    if ((state == ST_DEV_ACK) ? sreg[0] : ~sreg[0]) begin
                        osh      <= rd_data;
                        sda_oe_o <= ~rd_data[7];
                        ptr      <= ptr + ADDR_W'(1);
                    end else begin
                        sda_oe_o <= 1'b0;
                    end
                end
                ST_IDLE, ST_WADDR_ACK, ST_WDATA_ACK: sda_oe_o <= 1'b0;
                default: sda_oe_o <= 1'b0;
            endcase
        end
    end

    logic unused_pg;
    assign unused_pg = ^{PG_W};

endmodule

// File: rtl/eew_checker.sv
module eew_checker
    import eew_pkg::*;
#(
    parameter int WR_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       busy,
    input logic       scl_s,
    input logic       stop_det,
    input logic       buf_any,
    input eew_state_e st
);
    int unsigned bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt <= 0;
        end else if (busy) begin
            bcnt <= bcnt + 1;
        end else begin
            bcnt <= 0;
        end
    end

    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe); // R8
    AST_BUSY_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == WR_CYCLES)); // R7
    AST_LAUNCH_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det)); // R7
    AST_LAUNCH_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(buf_any)); // R11
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe); // R2

endmodule

bind eeprom_wr_slave eew_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .busy(busy_o), .scl_s(scl_s),
    .stop_det(stop_det), .buf_any(buf_any), .st(state)
);

// File: tb/sim_eeprom_wr_slave.sv
module sim_eeprom_wr_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q  = 8;
    localparam int WR = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] pins = 3'b101;
    logic       sda_oe, busy;
    logic       sda_line;

    assign sda_line = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_wr_slave #(.WR_CYCLES(WR)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .addr_pins_i(pins), .sda_oe_o(sda_oe), .busy_o(busy)
    );

    int checks = 0;
    int fails  = 0;

    // behavioural reference model
    logic [7:0] ref_mem [128];
    logic [7:0] mb [8];
    bit         mv [8];
    int         ma = 0, m_arm = 0, m_cnt = 0, m_page = 0;

    function automatic bit model_idle();
        return (m_arm == 0) && (m_cnt == 0);
    endfunction

    function automatic bit model_any();
        bit a = 0;
        for (int i = 0; i < 8; i++) a |= mv[i];
        return a;
    endfunction

    always @(posedge clk) begin
        if (m_arm > 0) begin
            m_arm--;
            if (m_arm == 0) m_cnt = WR;
        end else if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                for (int i = 0; i < 8; i++) begin
                    if (mv[i]) ref_mem[m_page*8 + i] = mb[i];
                    mv[i] = 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compared on every clock: busy window (R7) and silence while busy (R8)
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy === (m_cnt != 0), "R7 busy vs model", int'(busy), int'(m_cnt != 0));
            if (m_cnt != 0) chk(sda_oe === 1'b0, "R8 sda_oe while busy", int'(sda_oe), 0);
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0;
        if (model_idle()) for (int i = 0; i < 8; i++) mv[i] = 0;
        wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1;
        if (model_idle() && model_any()) begin
            m_arm  = 3;
            m_page = ma / 8;
        end
        wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq();
            m_scl = 1'b1; wq(); wq();
            m_scl = 1'b0;
        end
        wq();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        ack = (sda_line == 1'b0);
        wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic send_data(input logic [7:0] d, output bit ack);
        send_byte(d, ack);
        if (ack) begin
            mb[ma % 8] = d;
            mv[ma % 8] = 1;
            ma = (ma & ~7) | ((ma + 1) & 7);
        end
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            m_scl = 1'b1; wq();
            b[i] = sda_line;
            wq();
            m_scl = 1'b0; wq();
        end
        m_sda = nack; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit a;
        int tries;
        logic [7:0] got [8];
        logic [7:0] rb;
        for (int i = 0; i < 128; i++) ref_mem[i] = 8'h00;
        for (int i = 0; i < 8; i++) mv[i] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R13: reset state
        chk(busy == 1'b0, "R13 busy after reset", int'(busy), 0);
        chk(sda_oe == 1'b0, "R13 sda_oe after reset", int'(sda_oe), 0);

        // R2: pin mismatch, then a following byte is ignored
        bus_start();
        send_byte(8'hA4, a);
        chk(!a, "R2 pin mismatch nack", int'(a), 0);
        send_byte(8'h00, a);
        chk(!a, "R2 later byte ignored", int'(a), 0);
        bus_stop();

        // R1: wrong prefix
        bus_start();
        send_byte(8'hBA, a);
        chk(!a, "R1 prefix mismatch nack", int'(a), 0);
        bus_stop();

        // R3/R4: byte write 0xA5 to 0x10
        bus_start();
        send_byte(8'hAA, a);
        chk(a, "R3 device ack", int'(a), 1);
        send_byte(8'h10, a); ma = 'h10;
        chk(a, "R4 word address ack", int'(a), 1);
        send_data(8'hA5, a);
        chk(a, "R4 data ack", int'(a), 1);
        bus_stop();

        // R8/R9: acknowledge polling
        tries = 0;
        a = 0;
        while (!a && tries < 60) begin
            bus_start();
            send_byte(8'hAA, a);
            tries++;
            if (!a) bus_stop();
        end
        chk(a, "R9 poll eventually acked", int'(a), 1);
        chk(tries > 1, "R8 first poll refused", tries, 2);
        send_byte(8'h10, a); ma = 'h10;
        chk(a, "R9 transfer proceeds", int'(a), 1);
        bus_start();
        send_byte(8'hAB, a);
        chk(a, "R10 read device ack", int'(a), 1);
        recv_byte(1'b1, rb);
        chk(rb == 8'hA5, "R10 random read", int'(rb), 'hA5);
        bus_stop();

        // R11: stop before any data byte
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'h20, a); ma = 'h20;
        bus_stop();
        repeat (10) @(negedge clk);
        chk(busy == 1'b0, "R11 no write cycle", int'(busy), 0);

        // R5/R6: ten bytes from offset 5 of page 0x18
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'h1D, a); ma = 'h1D;
        for (int k = 0; k < 10; k++) begin
            send_data(8'h30 + 8'(k), a);
            chk(a, "R4 page data ack", int'(a), 1);
        end
        bus_stop();
        repeat (WR + 20) @(negedge clk);
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'h18, a);
        bus_start();
        send_byte(8'hAB, a);
        for (int i = 0; i < 8; i++) begin
            recv_byte(i == 7, got[i]);
            chk(got[i] == ref_mem['h18 + i], "R5 page readback", int'(got[i]), int'(ref_mem['h18 + i]));
        end
        bus_stop();
        chk(got[0] == 8'h33, "R5 wrap to page start", int'(got[0]), 'h33);
        chk(got[5] == 8'h38, "R6 overwrite offset 5", int'(got[5]), 'h38);
        chk(got[4] == 8'h37, "R5 offset 4 last in lap", int'(got[4]), 'h37);

        // R10: current-address read continues past the page
        bus_start();
        send_byte(8'hAB, a);
        recv_byte(1'b1, rb);
        chk(rb == ref_mem['h20], "R10 current address read", int'(rb), int'(ref_mem['h20]));
        bus_stop();

        // R12: repeated start drops the buffered byte
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'h40, a); ma = 'h40;
        send_data(8'h77, a);
        chk(a, "R12 data ack before restart", int'(a), 1);
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'h40, a); ma = 'h40;
        bus_stop();
        repeat (10) @(negedge clk);
        chk(busy == 1'b0, "R12 no write cycle", int'(busy), 0);
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'h40, a);
        bus_start();
        send_byte(8'hAB, a);
        recv_byte(1'b1, rb);
        chk(rb == 8'h00, "R12 array unchanged", int'(rb), 0);
        bus_stop();

        repeat (20) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule